// File: doc/BRIEF.md
# Table-Coded Clock Divider Bank

This block drives several clock-enable outputs from a single source clock. Each output divides the source by a ratio picked from a fixed, irregular table of sixteen entries, two of which are reserved. Software selects a 4-bit code per output through a small register port. The codes for all outputs sit as separate fields in one shared control word. A new code is only staged when it is written. Nothing changes on the outputs until software sets the commit (kick) bit in a second register. All staged codes are then applied as one set.

Each output switches to its new ratio at the end of the period it is currently running, so no shortened pulse is ever produced. The kick bit reads back as 1 while a commit is in flight. It drops to 0 by itself once every output has switched. Each output also carries a legal-code mask. A write of a code that the mask forbids is discarded for that field. Outputs are single-cycle enable pulses in the source clock domain, one per divided period. They run from reset with legal default codes and need no software setup.

A commit controller with three named states sequences each commit. In IDLE it waits for a kick write, then takes the transition "kick accepted" to LAUNCH. In LAUNCH it spends one cycle issuing an arm pulse that copies every staged code into each divider, then takes the transition "armed" to WAIT. In WAIT it stays until every divider reports that it has switched, then takes the transition "all switched" back to IDLE. Each divider has two named states. In RUN its new code has been applied. On "arm" it moves to ARMED, where a code is waiting. On "period end" it applies that code and returns to RUN.

Top module: `cdb_bank`

## Requirements
- R1: The active code selects the divide ratio: codes 0..15 give 2, 3, 4, 6, 8, 12, 16, 18, 24, 32, 36, 48, reserved, 72, 96, reserved. Both reserved codes are forbidden by every mask.
- R2: Register address 0 holds the output fields, 4 bits each: output 0 at bits 23:20, output 1 at 19:16, output 2 at 11:8, output 3 at 7:4. All other bits read 0. Register address 1 carries the kick bit at bit 31, and its other bits read 0.
- R3: After reset, with no writes, the committed codes are 2, 0, 1 and 2 for outputs 0..3, so the outputs run at ratios 4, 2, 3 and 4.
- R4: A code write only stages the value. Reading address 0 still returns the committed codes, and the output periods keep their old ratios until a kick.
- R5: Writing address 1 with bit 31 set starts a commit. Bit 31 then reads 1 until every output has switched, then reads 0. Committed codes change only while a commit is in flight.
- R6: Outputs 0..2 accept codes allowed by mask 0x6fff, and output 3 accepts codes allowed by mask 0x677c. Bit n of a mask set means code n is legal. A forbidden code written to a field is ignored, and that field keeps its previous value through later commits.
- R7: An output switches ratio only at the end of its current period. The period during which a kick arrives completes with the old ratio, and the following period uses the new one.
- R8: Each output pulses high for exactly one source cycle per period, and consecutive pulses are exactly the ratio apart.
- R9: A write to address 1 with bit 31 clear starts no commit and changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address (0 codes, 1 kick) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read address |
| reg_rdata | output | 32 | Read data, combinational from read address |
| tick_o | output | 4 | One clock-enable pulse per output per divided period |

## Verification
The assertions take for granted a single write port. They also assume a kick is written only while the previous commit has finished, and that reset is applied before the first kick. The stimulus keeps within these assumptions. It stages codes and kicks only after polling the kick bit back to 0. It also lets the scoreboard drain all period measurements before changing any setting, so every measured period belongs to one settled ratio. The only exception is the deliberate mid-period kick that probes the boundary rule.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

    localparam int CODE_W = 4;
    localparam int CNT_W  = 7;

    typedef enum logic [1:0] {
        CM_IDLE   = 2'd0,
        CM_LAUNCH = 2'd1,
        CM_WAIT   = 2'd2
    } commit_state_t;

    typedef enum logic {
        DV_RUN   = 1'b0,
        DV_ARMED = 1'b1
    } div_state_t;

    // Divide ratio for a code; reserved codes fall back to a harmless 2.
    function automatic logic [CNT_W-1:0] code_ratio(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] r;
        unique case (code)
            4'd0:  r = 7'd2;
            4'd1:  r = 7'd3;
            4'd2:  r = 7'd4;
            4'd3:  r = 7'd6;
            4'd4:  r = 7'd8;
            4'd5:  r = 7'd12;
            4'd6:  r = 7'd16;
            4'd7:  r = 7'd18;
            4'd8:  r = 7'd24;
            4'd9:  r = 7'd32;
            4'd10: r = 7'd36;
            4'd11: r = 7'd48;
            4'd13: r = 7'd72;
            4'd14: r = 7'd96;
            default: r = 7'd2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cdb_divider.sv
module cdb_divider
    import cdb_pkg::*;
#(
    parameter logic [15:0]       LEGAL    = 16'h6fff,
    parameter logic [CODE_W-1:0] RST_CODE = 4'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fld_we,
    input  logic [CODE_W-1:0] fld_data,
    input  logic              arm,
    output logic              tick,
    output logic              done,
    output logic [CODE_W-1:0] code_o
);

    div_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] next_q;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  last_cnt;
    logic              wrap;
    logic              apply;

    assign last_cnt = code_ratio(code_q) - 7'd1;
    assign wrap     = (cnt_q == last_cnt);
    assign apply    = (state_q == DV_ARMED) && wrap;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DV_RUN:   if (arm)  state_d = DV_ARMED;
            DV_ARMED: if (wrap) state_d = DV_RUN;
            default:            state_d = DV_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DV_RUN;
        else        state_q <= state_d;
    end

    // Datapath: staging, snapshot, active code and period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= RST_CODE;
            next_q  <= RST_CODE;
            code_q  <= RST_CODE;
            cnt_q   <= '0;
        end else begin
            if (fld_we && LEGAL[fld_data])
                stage_q <= fld_data;
            if (arm && state_q == DV_RUN)
                next_q <= stage_q;
            if (apply)
                code_q <= next_q;
            if (wrap) cnt_q <= '0;
            else      cnt_q <= cnt_q + 7'd1;
        end
    end

    // Outputs
    always_comb begin
        tick   = wrap;
        done   = (state_q == DV_RUN);
        code_o = code_q;
    end

endmodule

// File: rtl/cdb_commit_fsm.sv
module cdb_commit_fsm
    import cdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kick_req,
    input  logic all_done,
    output logic arm,
    output logic busy
);

    commit_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CM_IDLE:   if (kick_req) state_d = CM_LAUNCH;
            CM_LAUNCH:               state_d = CM_WAIT;
            CM_WAIT:   if (all_done) state_d = CM_IDLE;
            default:                 state_d = CM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        arm  = (state_q == CM_LAUNCH);
        busy = (state_q != CM_IDLE);
    end

endmodule

// File: rtl/cdb_bank.sv
module cdb_bank
    import cdb_pkg::*;
#(
    parameter int                      NUM_OUT   = 4,
    parameter int                      ADDR_W    = 4,
    parameter int                      DATA_W    = 32,
    parameter int                      KICK_BIT  = 31,
    parameter logic [NUM_OUT*8-1:0]    FIELD_LSB = {8'd4, 8'd8, 8'd16, 8'd20},
    parameter logic [NUM_OUT*16-1:0]   LEGAL     = {16'h677c, 16'h6fff, 16'h6fff, 16'h6fff},
    parameter logic [NUM_OUT*4-1:0]    RST_CODES = {4'd2, 4'd1, 4'd0, 4'd2}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_waddr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [ADDR_W-1:0]  reg_raddr,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_OUT-1:0] tick_o
);

    localparam logic [ADDR_W-1:0] CODE_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] KICK_ADDR = ADDR_W'(1);
    localparam int                FLAT_W    = NUM_OUT * CODE_W;

    logic                 code_we;
    logic                 kick_req;
    logic                 arm;
    logic                 busy;
    logic [NUM_OUT-1:0]   done_vec;
    logic [FLAT_W-1:0]    code_flat;
    logic [DATA_W-1:0]    code_word;

    assign code_we  = reg_we && (reg_waddr == CODE_ADDR);
    assign kick_req = reg_we && (reg_waddr == KICK_ADDR) && reg_wdata[KICK_BIT];

    cdb_commit_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick_req (kick_req),
        .all_done (&done_vec),
        .arm      (arm),
        .busy     (busy)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
        localparam int LSB = int'(FIELD_LSB[g*8 +: 8]);
        cdb_divider #(
            .LEGAL    (LEGAL[g*16 +: 16]),
            .RST_CODE (RST_CODES[g*CODE_W +: CODE_W])
        ) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .fld_we   (code_we),
            .fld_data (reg_wdata[LSB +: CODE_W]),
            .arm      (arm),
            .tick     (tick_o[g]),
            .done     (done_vec[g]),
            .code_o   (code_flat[g*CODE_W +: CODE_W])
        );
    end

    // Committed codes placed at their field positions
    always_comb begin
        code_word = '0;
        for (int i = 0; i < NUM_OUT; i++)
            code_word[int'(FIELD_LSB[i*8 +: 8]) +: CODE_W] = code_flat[i*CODE_W +: CODE_W];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_raddr == CODE_ADDR)
            reg_rdata = code_word;
        else if (reg_raddr == KICK_ADDR)
            reg_rdata[KICK_BIT] = busy;
    end

endmodule

// File: rtl/cdb_bank_chk.sv
module cdb_bank_chk #(
    parameter int                    NUM_OUT  = 4,
    parameter int                    ADDR_W   = 4,
    parameter int                    DATA_W   = 32,
    parameter int                    KICK_BIT = 31,
    parameter logic [NUM_OUT*16-1:0] LEGAL    = '1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [ADDR_W-1:0]    reg_waddr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [NUM_OUT-1:0]   tick_o,
    input logic [NUM_OUT*4-1:0] code_flat,
    input logic                 busy
);

    logic kick_wr;
    assign kick_wr = reg_we && (reg_waddr == ADDR_W'(1)) && reg_wdata[KICK_BIT];

    AST_COMMIT_STARTS_ON_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(kick_wr)); // R5

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
        AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o[g] |=> !tick_o[g]); // R8

        AST_SWITCH_AT_PERIOD_END: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(code_flat[g*4 +: 4]) |-> $past(tick_o[g])); // R7

        AST_SWITCH_ONLY_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(code_flat[g*4 +: 4]) |-> $past(busy)); // R5

        AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            LEGAL[g*16 + int'(code_flat[g*4 +: 4])]); // R6
    end

endmodule

bind cdb_bank cdb_bank_chk #(
    .NUM_OUT  (NUM_OUT),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .KICK_BIT (KICK_BIT),
    .LEGAL    (LEGAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .tick_o    (tick_o),
    .code_flat (code_flat),
    .busy      (busy)
);

// File: tb/cdb_bank_test.sv
module cdb_bank_test;

    typedef struct {
        int    idx;
        int    ratio;
        string req;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  tick_o;

    int       n_checks = 0;
    int       n_fail = 0;
    bit       mon_busy = 1'b0;
    bit       done_flag = 1'b0;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    cdb_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .tick_o    (tick_o)
    );

    function automatic logic [31:0] fields(int c0, int c1, int c2, int c3);
        return (32'(c0) << 20) | (32'(c1) << 16) | (32'(c2) << 8) | (32'(c3) << 4);
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic reg_write(logic [3:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(logic [3:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    // Driver: queue an expected period for the monitor
    task automatic expect_period(int idx, int ratio, string req);
        sb_item_t it;
        it.idx = idx; it.ratio = ratio; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        while (sb_q.size() != 0 || mon_busy) @(negedge clk);
    endtask

    task automatic kick_and_wait(string req);
        logic [31:0] d;
        int waited;
        reg_write(4'd1, 32'h8000_0000);
        reg_read(4'd1, d);
        check({req, " kick bit set while committing"}, d, 32'h8000_0000);
        waited = 0;
        do begin
            @(negedge clk);
            reg_read(4'd1, d);
            waited++;
        end while (d[31] && waited < 400);
        check({req, " kick bit self-clears"}, d, 32'h0);
    endtask

    // Monitor: measures one period per queued item and compares
    initial begin
        sb_item_t it;
        int n;
        forever begin
            while (sb_q.size() == 0) @(negedge clk);
            mon_busy = 1'b1;
            it = sb_q.pop_front();
            do @(negedge clk); while (!tick_o[it.idx]);
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!tick_o[it.idx] && n < 200);
            n_checks++;
            if (n != it.ratio) begin
                n_fail++;
                $display("FAIL %s: out%0d period got %0d expected %0d", it.req, it.idx, n, it.ratio);
            end
            mon_busy = 1'b0;
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R3: reset readback and reset ratios
        reg_read(4'd0, d);
        check("R3 reset codes at R2 field positions", d, fields(2, 0, 1, 2));
        reg_read(4'd1, d);
        check("R2 kick register idle", d, 32'h0);
        expect_period(0, 4, "R3");
        expect_period(1, 2, "R3");
        expect_period(2, 3, "R3");
        expect_period(3, 4, "R8");
        drain();

        // R4: staged codes do not show or take effect before a kick
        reg_write(4'd0, fields(13, 5, 4, 9));
        reg_read(4'd0, d);
        check("R4 read returns committed code", d, fields(2, 0, 1, 2));
        expect_period(0, 4, "R4");
        expect_period(2, 3, "R4");
        drain();

        // R9: kick register written with bit 31 clear
        reg_write(4'd1, 32'h7fff_ffff);
        reg_read(4'd1, d);
        check("R9 no commit started", d, 32'h0);
        reg_read(4'd0, d);
        check("R9 codes unchanged", d, fields(2, 0, 1, 2));
        expect_period(1, 2, "R9");
        drain();

        // R1, R5: commit a new set
        kick_and_wait("R5");
        reg_read(4'd0, d);
        check("R5 committed codes after kick", d, fields(13, 5, 4, 9));
        expect_period(0, 72, "R1");
        expect_period(1, 12, "R1");
        expect_period(2, 8, "R1");
        expect_period(3, 32, "R1");
        drain();

        // R6: forbidden codes ignored per output mask
        reg_write(4'd0, fields(15, 12, 14, 0));
        kick_and_wait("R6");
        reg_read(4'd0, d);
        check("R6 forbidden codes ignored", d, fields(13, 5, 14, 9));
        expect_period(0, 72, "R6");
        expect_period(1, 12, "R6");
        expect_period(2, 96, "R1");
        expect_period(3, 32, "R6");
        drain();

        // R1: more table entries
        reg_write(4'd0, fields(3, 11, 1, 6));
        kick_and_wait("R1");
        reg_read(4'd0, d);
        check("R1 second code set committed", d, fields(3, 11, 1, 6));
        expect_period(0, 6, "R1");
        expect_period(1, 48, "R1");
        expect_period(2, 3, "R1");
        expect_period(3, 16, "R1");
        drain();

        // R7: kick arrives mid-period on output 2 (3 -> 8)
        reg_write(4'd0, fields(3, 11, 4, 6));
        do @(negedge clk); while (!tick_o[2]);
        reg_write(4'd1, 32'h8000_0000);
        n = 1;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_o[2] && n < 200);
        check("R7 period in flight keeps old ratio", 32'(n), 32'd3);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_o[2] && n < 200);
        check("R7 next period uses new ratio", 32'(n), 32'd8);
        repeat (120) @(negedge clk);
        reg_read(4'd1, d);
        check("R5 kick cleared after mid-period commit", d, 32'h0);

        finish_run();
    end

endmodule